// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block is the device-side timing model of a synchronous DRAM's column path. It holds the mode settings loaded by a mode-register-set command: burst length, wrap order and read latency. For every read or write it then walks the burst's column addresses one per clock. The storage array is not part of the block. The array side uses the column address, the write byte enables and the bank number. The data-bus side uses the delayed read-data enable and the read byte enables.

The command inputs arrive already decoded as one strobe per command. The block honours the mode-write wait time. It lets a burst stop or a new read or write cut the current burst short. It applies the byte-mask input with a latency of zero cycles on writes and two cycles on reads.

Top module: `sdram_burst_ctl`

## Requirements
- R1: A mode write (`mrs_i`) taken while `banks_idle_i` is high loads the mode from the address pins. The bits are `addr_i[2:0]` for length (000=1, 001=2, 010=4, 011=8, 111=full page), `addr_i[3]` for order (0 sequential, 1 interleaved) and `addr_i[6:4]` for read latency (010=2, 011=3). The new mode governs the next accepted read or write. After reset the mode is length 1, sequential, latency 3.
- R2: A mode write is rejected and the old mode kept if `banks_idle_i` is low, if the length code is 100, 101 or 110, or if the latency code is neither 010 nor 011.
- R3: In the cycle right after an accepted mode write, read, write and mode strobes are ignored. They are accepted again from the second cycle on.
- R4: An accepted read or write with length L drives `col_vld_o` high for exactly L consecutive cycles, starting in the command cycle itself. `col_wr_o` gives the direction, and `col_vld_o` is low when no burst runs.
- R5: In sequential order, beat k carries the start column with its low log2(L) bits replaced by (start + k) mod L.
- R6: In interleaved order, beat k carries the start column XOR k.
- R7: In full-page mode, beat k carries (start + k) mod 1024 and the burst runs on until stopped or replaced. The order bit has no effect in this mode.
- R8: A burst stop strobe (`bst_i`) yields no beat in its own cycle or after it.
- R9: A read or write accepted during a burst ends that burst and starts the new one in the same cycle.
- R10: Each read beat seen on `col_vld_o` in cycle n raises `rd_vld_o` in cycle n + latency.
- R11: During a write beat `wr_be_o` equals the inverse of `dqm_i` in that same cycle. It is zero in every other cycle.
- R12: `rd_be_o` in cycle n equals the inverse of `dqm_i` from cycle n-2 when `rd_vld_o` is high. It is zero otherwise.
- R13: `bank_o` carries the bank taken with the command and holds it for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrs_i | input | 1 | Mode register write strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| bst_i | input | 1 | Burst stop strobe |
| banks_idle_i | input | 1 | All banks precharged |
| addr_i | input | 12 | Address pins: mode key or start column |
| ba_i | input | 2 | Bank select |
| dqm_i | input | 9 | Byte mask, one bit per byte lane |
| col_o | output | 10 | Column address of the current beat |
| bank_o | output | 2 | Bank of the current burst |
| col_vld_o | output | 1 | A beat is present this cycle |
| col_wr_o | output | 1 | The present beat is a write |
| wr_be_o | output | 9 | Write byte enables for the present beat |
| rd_vld_o | output | 1 | Read data drive enable, delayed by the latency |
| rd_be_o | output | 9 | Per-lane read drive enables after the read mask |

## Verification
The byte-mask input serves two purposes at once. It masks the write beat in the cycle where it is driven, and it also decides which read lanes drive two cycles later. Both happen together when a write cuts into a read whose data is still leaving the latency pipeline. The bench provokes this by starting an interleaved read, replacing it with a write two cycles later, and varying the mask on every cycle. The scoreboard then compares each cycle's `wr_be_o` against that cycle's mask. It compares each cycle's `rd_be_o` against the mask from two cycles earlier, on the same clock on which the overlapping read data is enabled.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int COL_W  = 10;
  localparam int MAX_CL = 3;

  typedef struct packed {
    logic [COL_W-1:0] len_mask;   // burst length minus one
    logic             full_page;
    logic             interleave;
    logic [1:0]       cas_lat;
  } mode_t;

  localparam mode_t MODE_RST = '{len_mask: '0, full_page: 1'b0,
                                 interleave: 1'b0, cas_lat: 2'd3};
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int MRD_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mrs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       banks_idle_i,
  input  logic [6:0] key_i,
  output mode_t      mode_o,
  output logic       rd_o,
  output logic       wr_o
);
  localparam int LOCK_W = $clog2(MRD_CYC + 1);
  localparam logic [LOCK_W-1:0] LOCK_INIT = LOCK_W'(MRD_CYC - 1);

  logic [LOCK_W-1:0] lock_q;
  logic              locked, len_ok, cl_ok, accept;
  mode_t             mode_q, mode_d;

  assign locked = (lock_q != '0);

  always_comb begin
    mode_d            = mode_q;
    len_ok            = 1'b1;
    cl_ok             = 1'b1;
    mode_d.full_page  = 1'b0;
    mode_d.interleave = key_i[3];
    unique case (key_i[2:0])
      3'b000:  mode_d.len_mask = COL_W'(0);
      3'b001:  mode_d.len_mask = COL_W'(1);
      3'b010:  mode_d.len_mask = COL_W'(3);
      3'b011:  mode_d.len_mask = COL_W'(7);
      3'b111: begin
        mode_d.len_mask  = '1;
        mode_d.full_page = 1'b1;
      end
      default: len_ok = 1'b0;
    endcase
    unique case (key_i[6:4])
      3'b010:  mode_d.cas_lat = 2'd2;
      3'b011:  mode_d.cas_lat = 2'd3;
      default: cl_ok = 1'b0;
    endcase
  end

  assign accept = mrs_i & banks_idle_i & ~locked & len_ok & cl_ok;
  assign rd_o   = rd_i & ~locked;
  assign wr_o   = wr_i & ~locked;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      lock_q <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
      lock_q <= LOCK_INIT;
    end else if (locked) begin
      lock_q <= lock_q - LOCK_W'(1);
    end
  end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_burst_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              bst_i,
  input  logic [COL_W-1:0]  start_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [COL_W-1:0]  len_mask_i,
  input  logic              full_page_i,
  input  logic              interleave_i,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              beat_o,
  output logic              beat_wr_o
);
  logic              act_q, wr_q, last, act_d;
  logic [COL_W-1:0]  base_q, cnt_q, base, cnt;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    base      = base_q;
    cnt       = cnt_q;
    bank_o    = bank_q;
    beat_wr_o = wr_q;
    beat_o    = act_q;
    // a new command pre-empts the running burst; first beat is this cycle
    if (rd_i || wr_i) begin
      base      = start_i;
      cnt       = '0;
      bank_o    = ba_i;
      beat_wr_o = wr_i;
      beat_o    = 1'b1;
    end else if (bst_i) begin
      beat_o = 1'b0;
    end
    if (interleave_i && !full_page_i)
      col_o = base ^ cnt;
    else
      col_o = (base & ~len_mask_i) | ((base + cnt) & len_mask_i);
    last  = !full_page_i && (cnt == len_mask_i);
    act_d = beat_o && !last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else begin
      act_q <= act_d;
      if (beat_o) begin
        base_q <= base;
        cnt_q  <= cnt + COL_W'(1);
        wr_q   <= beat_wr_o;
        bank_q <= bank_o;
      end
    end
  end
endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
  import sdram_burst_pkg::*;
#(
  parameter int NB         = 9,
  parameter int RD_DQM_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          beat_wr_i,
  input  logic [1:0]    cas_lat_i,
  input  logic [NB-1:0] dqm_i,
  output logic [NB-1:0] wr_be_o,
  output logic          rd_vld_o,
  output logic [NB-1:0] rd_be_o
);
  logic [MAX_CL-1:0] rd_sh_q;
  logic [NB-1:0]     dqm_sh_q [RD_DQM_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sh_q <= '0;
    else         rd_sh_q <= {rd_sh_q[MAX_CL-2:0], beat_i & ~beat_wr_i};
  end

  for (genvar g = 0; g < RD_DQM_LAT; g++) begin : g_dqm
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dqm_sh_q[g] <= '0;
        else         dqm_sh_q[g] <= dqm_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dqm_sh_q[g] <= '0;
        else         dqm_sh_q[g] <= dqm_sh_q[g-1];
      end
    end
  end

  assign rd_vld_o = rd_sh_q[cas_lat_i - 2'd1];
  assign rd_be_o  = rd_vld_o ? ~dqm_sh_q[RD_DQM_LAT-1] : '0;
  assign wr_be_o  = (beat_i && beat_wr_i) ? ~dqm_i : '0;
endmodule

// File: rtl/sdram_burst_ctl.sv
module sdram_burst_ctl
  import sdram_burst_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int NB         = 9,
  parameter int MRD_CYC    = 2,
  parameter int RD_DQM_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              bst_i,
  input  logic              banks_idle_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [NB-1:0]     dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              col_vld_o,
  output logic              col_wr_o,
  output logic [NB-1:0]     wr_be_o,
  output logic              rd_vld_o,
  output logic [NB-1:0]     rd_be_o
);
  mode_t mode;
  logic  rd_ok, wr_ok, beat, beat_wr;
  logic  unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:COL_W];

  sdram_mode_reg #(.MRD_CYC(MRD_CYC)) u_mode (
    .clk_i, .rst_ni, .mrs_i, .rd_i, .wr_i, .banks_idle_i,
    .key_i (addr_i[6:0]),
    .mode_o(mode),
    .rd_o  (rd_ok),
    .wr_o  (wr_ok)
  );

  sdram_col_gen #(.BANK_W(BANK_W)) u_col (
    .clk_i, .rst_ni,
    .rd_i        (rd_ok),
    .wr_i        (wr_ok),
    .bst_i,
    .start_i     (addr_i[COL_W-1:0]),
    .ba_i,
    .len_mask_i  (mode.len_mask),
    .full_page_i (mode.full_page),
    .interleave_i(mode.interleave),
    .col_o,
    .bank_o,
    .beat_o      (beat),
    .beat_wr_o   (beat_wr)
  );

  sdram_dq_pipe #(.NB(NB), .RD_DQM_LAT(RD_DQM_LAT)) u_dq (
    .clk_i, .rst_ni,
    .beat_i   (beat),
    .beat_wr_i(beat_wr),
    .cas_lat_i(mode.cas_lat),
    .dqm_i,
    .wr_be_o,
    .rd_vld_o,
    .rd_be_o
  );

  assign col_vld_o = beat;
  assign col_wr_o  = beat & beat_wr;
endmodule

// File: rtl/sdram_burst_chk.sv
module sdram_burst_chk
  import sdram_burst_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int NB     = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic              bst_i,
  input logic [NB-1:0]     dqm_i,
  input mode_t             mode_i,
  input logic              col_vld_i,
  input logic              col_wr_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [NB-1:0]     wr_be_i,
  input logic              rd_vld_i,
  input logic [NB-1:0]     rd_be_i
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_wr_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_vld_i && col_wr_i) |-> (wr_be_i == ~dqm_i));

  p_wr_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(col_vld_i && col_wr_i) |-> (wr_be_i == '0));

  p_rd_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && rd_vld_i) |-> (rd_be_i == ~$past(dqm_i, 2)));

  p_rd_lat2_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && mode_i.cas_lat == 2'd2 && $past(mode_i.cas_lat, 2) == 2'd2)
      |-> (rd_vld_i == $past(col_vld_i && !col_wr_i, 2)));

  p_rd_lat3_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && mode_i.cas_lat == 2'd3 && $past(mode_i.cas_lat, 3) == 2'd3)
      |-> (rd_vld_i == $past(col_vld_i && !col_wr_i, 3)));

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_i && !rd_i && !wr_i) |-> !col_vld_i);

  p_bank_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && col_vld_i && !rd_i && !wr_i && $past(col_vld_i))
      |-> $stable(bank_i));
endmodule

bind sdram_burst_ctl sdram_burst_chk #(.BANK_W(BANK_W), .NB(NB)) u_chk (
  .clk_i, .rst_ni, .rd_i, .wr_i, .bst_i, .dqm_i,
  .mode_i   (mode),
  .col_vld_i(col_vld_o),
  .col_wr_i (col_wr_o),
  .bank_i   (bank_o),
  .wr_be_i  (wr_be_o),
  .rd_vld_i (rd_vld_o),
  .rd_be_i  (rd_be_o)
);

// File: tb/sim_sdram_burst_ctl.sv
module sim_sdram_burst_ctl;
  localparam int NB = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mrs = 0, rd = 0, wr = 0, bst = 0, idle = 1;
  logic [11:0]   addr = '0;
  logic [1:0]    ba = '0;
  logic [NB-1:0] dqm = '0;
  logic [9:0]    col;
  logic [1:0]    bank;
  logic          col_vld, col_wr, rd_vld;
  logic [NB-1:0] wr_be, rd_be;

  sdram_burst_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mrs_i(mrs), .rd_i(rd), .wr_i(wr), .bst_i(bst),
    .banks_idle_i(idle), .addr_i(addr), .ba_i(ba), .dqm_i(dqm),
    .col_o(col), .bank_o(bank), .col_vld_o(col_vld), .col_wr_o(col_wr),
    .wr_be_o(wr_be), .rd_vld_o(rd_vld), .rd_be_o(rd_be)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, done = 0;
  string idle_tag = "R4";

  // bench copy of the mode, from the requirements
  int b_len = 1, b_cl = 3;
  bit b_full = 0, b_il = 0;

  // scoreboard queues
  int          q_cyc[$];
  logic [9:0]  q_col[$];
  bit          q_wr[$];
  logic [1:0]  q_bank[$];
  string       q_tag[$];
  int          q_rd[$];
  logic [NB-1:0] hist [4];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [9:0] exp_col(logic [9:0] s, int k);
    logic [9:0] m;
    m = 10'(b_len - 1);
    if (b_full)    return 10'(s + 10'(k));
    else if (b_il) return s ^ 10'(k);
    else           return (s & ~m) | (10'(s + 10'(k)) & m);
  endfunction

  task automatic drv(bit m, bit r, bit w, bit s, bit id, logic [11:0] a,
                     logic [1:0] b, logic [NB-1:0] d);
    @(negedge clk);
    mrs = m; rd = r; wr = w; bst = s; idle = id; addr = a; ba = b; dqm = d;
  endtask

  task automatic nopd(int n, int seed);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 1, '0, '0, NB'(seed * 29 + i * 77));
  endtask

  task automatic push_burst(logic [9:0] s, logic [1:0] b, bit w, int beats, string tag);
    for (int k = 0; k < beats; k++) begin
      q_cyc.push_back(cyc + k);
      q_col.push_back(exp_col(s, k));
      q_wr.push_back(w);
      q_bank.push_back(b);
      q_tag.push_back(tag);
      if (!w) q_rd.push_back(cyc + k + b_cl);
    end
  endtask

  task automatic mrs_cmd(bit [2:0] blc, bit il, bit [2:0] clc, bit id, bit ok);
    drv(1, 0, 0, 0, id, 12'({clc, il, blc}), '0, '0);
    if (ok) begin
      b_full = (blc == 3'b111);
      b_len  = b_full ? 1024 : (1 << blc);
      b_il   = il;
      b_cl   = (clc == 3'b010) ? 2 : 3;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (mon_on && !done) begin
      bit exp_beat, exp_rdv;
      logic [NB-1:0] e_wbe, e_rbe;
      hist[cyc & 3] = dqm;
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        chk(0, q_tag[0], "beat missed", 0, q_cyc[0]);
        void'(q_cyc.pop_front()); void'(q_col.pop_front()); void'(q_wr.pop_front());
        void'(q_bank.pop_front()); void'(q_tag.pop_front());
      end
      exp_beat = (q_cyc.size() > 0 && q_cyc[0] == cyc);
      e_wbe = '0;
      if (exp_beat) begin
        chk(col_vld == 1'b1, q_tag[0], "col_vld", col_vld, 1);
        chk(col == q_col[0], q_tag[0], "col", col, q_col[0]);
        chk(col_wr == q_wr[0], q_tag[0], "col_wr", col_wr, q_wr[0]);
        chk(bank == q_bank[0], "R13", "bank", bank, q_bank[0]);
        if (q_wr[0]) e_wbe = ~dqm;
        void'(q_cyc.pop_front()); void'(q_col.pop_front()); void'(q_wr.pop_front());
        void'(q_bank.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(col_vld == 1'b0, idle_tag, "col_vld idle", col_vld, 0);
      end
      chk(wr_be == e_wbe, "R11", "wr_be", wr_be, e_wbe);
      while (q_rd.size() > 0 && q_rd[0] < cyc) begin
        chk(0, "R10", "rd_vld missed", 0, q_rd[0]);
        void'(q_rd.pop_front());
      end
      exp_rdv = (q_rd.size() > 0 && q_rd[0] == cyc);
      if (exp_rdv) void'(q_rd.pop_front());
      chk(rd_vld == exp_rdv, "R10", "rd_vld", rd_vld, exp_rdv);
      e_rbe = exp_rdv ? ~hist[(cyc - 2) & 3] : '0;
      chk(rd_be == e_rbe, "R12", "rd_be", rd_be, e_rbe);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // reset state
    chk(col_vld == 0, "R4", "reset col_vld", col_vld, 0);
    chk(rd_vld == 0, "R10", "reset rd_vld", rd_vld, 0);
    chk(wr_be == '0, "R11", "reset wr_be", wr_be, 0);
    chk(rd_be == '0, "R12", "reset rd_be", rd_be, 0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1;
    nopd(2, 0);

    // R1 reset mode: length 1, latency 3
    drv(0, 1, 0, 0, 1, 12'h155, 2'd2, '0);
    push_burst(10'h155, 2'd2, 0, 1, "R1");
    nopd(6, 1);

    // R1/R3: length 4 sequential latency 2, write in lockout cycle ignored
    mrs_cmd(3'b010, 0, 3'b010, 1, 1);
    idle_tag = "R3";
    drv(0, 0, 1, 0, 1, 12'h0AA, 2'd3, '0);
    drv(0, 0, 1, 0, 1, 12'h0E6, 2'd1, 9'h0F0);
    push_burst(10'h0E6, 2'd1, 1, 4, "R5");
    idle_tag = "R4";
    nopd(6, 2);

    // R5 wrap at the top of the column space, R10/R12 with latency 2
    drv(0, 1, 0, 0, 1, 12'h3FD, 2'd0, 9'h1FF);
    push_burst(10'h3FD, 2'd0, 0, 4, "R5");
    nopd(8, 3);

    // R6 interleaved length 8, latency 3
    mrs_cmd(3'b011, 1, 3'b011, 1, 1);
    nopd(1, 4);
    drv(0, 1, 0, 0, 1, 12'h013, 2'd2, 9'h055);
    push_burst(10'h013, 2'd2, 0, 8, "R6");
    nopd(12, 5);

    // R2: three rejected mode writes, old mode must survive
    mrs_cmd(3'b100, 0, 3'b010, 1, 0);
    mrs_cmd(3'b010, 0, 3'b010, 0, 0);
    mrs_cmd(3'b011, 0, 3'b101, 1, 0);
    nopd(1, 6);
    drv(0, 1, 0, 0, 1, 12'h02C, 2'd1, '0);
    push_burst(10'h02C, 2'd1, 0, 8, "R2");
    nopd(12, 7);

    // R8 burst stop after three beats
    drv(0, 1, 0, 0, 1, 12'h020, 2'd0, '0);
    push_burst(10'h020, 2'd0, 0, 3, "R8");
    nopd(2, 8);
    idle_tag = "R8";
    drv(0, 0, 0, 1, 1, '0, '0, 9'h0C3);
    nopd(10, 9);
    idle_tag = "R4";

    // R9 read cut by a write; read data and write masks overlap
    drv(0, 1, 0, 0, 1, 12'h1F0, 2'd1, 9'h111);
    push_burst(10'h1F0, 2'd1, 0, 2, "R9");
    nopd(1, 10);
    drv(0, 0, 1, 0, 1, 12'h105, 2'd3, 9'h0A5);
    push_burst(10'h105, 2'd3, 1, 8, "R9");
    nopd(12, 11);

    // R7 full page, order bit set but without effect, latency 2
    mrs_cmd(3'b111, 1, 3'b010, 1, 1);
    nopd(1, 12);
    drv(0, 1, 0, 0, 1, 12'h3FE, 2'd2, '0);
    push_burst(10'h3FE, 2'd2, 0, 1030, "R7");
    nopd(1029, 13);
    idle_tag = "R8";
    drv(0, 0, 0, 1, 1, '0, '0, '0);
    nopd(6, 14);
    idle_tag = "R4";

    // R4 length 2 write at the last column
    mrs_cmd(3'b001, 0, 3'b011, 1, 1);
    nopd(1, 15);
    drv(0, 0, 1, 0, 1, 12'h3FF, 2'd0, 9'h1A5);
    push_burst(10'h3FF, 2'd0, 1, 2, "R4");
    nopd(8, 16);

    #2;
    chk(q_cyc.size() == 0, "R4", "beats left", q_cyc.size(), 0);
    chk(q_rd.size() == 0, "R10", "reads left", q_rd.size(), 0);
    finish_run();
  end
endmodule